// File: doc/BRIEF.md
# Per-Core Event Pulse Generator

This unit sits beside one processor core and turns three kinds of happening into single-clock event pulses that an interrupt dispatcher or a polling instruction can consume. The first source is a programmable down-counter that pulses each time it reloads. The second watches one pin out of a 64-bit input vector for a chosen kind of transition. The third compares the core's current execution address against a programmed breakpoint address.

Each source has its own setup write port: a 32-bit period, an 8-bit edge setting, and a 20-bit breakpoint address. The edge setting carries both the transition type and the pin index, so the edge type is chosen independently of how the pulse is used downstream. The breakpoint compare spans the whole 20-bit execution address space. The low region up to 0x7FC holds core-local code, and everything above it holds code fetched from shared memory. Pins are assumed to be synchronised before they reach this unit.

Top module: `evt_source_unit`

## Requirements
- R1: After reset all three event outputs are low, the timer is off (period 0), edge detection is off and the breakpoint is disarmed.
- R2: After a period value P (P >= 1) is written in one cycle, `tmr_evt` is first high P cycles after that write and then every P cycles, high for one cycle each time. With P = 1 it is high every cycle.
- R3: While the period is 0 `tmr_evt` stays low.
- R4: Writing a period while a count is in progress discards that count and restarts from the new value.
- R5: The edge setting uses bits [7:6] as the edge type and bits [5:0] as the pin index. The edge types are 00 off, 01 rising, 10 falling and 11 either edge.
- R6: A transition of the selected pin that matches the edge type raises `edge_evt` for one cycle. The pulse appears in the cycle after the clock edge that first samples the new pin level.
- R7: Writing the edge setting reloads the stored previous level from the newly selected pin, so the write itself never produces a pulse. Pins that are not selected have no effect on `edge_evt`.
- R8: Once armed, `brk_evt` pulses for one cycle in the cycle after the execution address becomes equal to the breakpoint address. The address must not have been equal on the previous cycle, so an address held at the breakpoint gives only one pulse.
- R9: The breakpoint is disarmed until its first write, after which it matches any 20-bit address. This includes both sides of the local/shared boundary (0x7FC and 0x800) and 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 64 | Synchronised pin levels |
| exec_addr | input | 20 | Current execution address |
| period_we | input | 1 | Write strobe for the timer period |
| period_wdata | input | 32 | New timer period, 0 turns the timer off |
| edge_we | input | 1 | Write strobe for the edge setting |
| edge_wdata | input | 8 | Edge type [7:6] and pin index [5:0] |
| brk_we | input | 1 | Write strobe for the breakpoint address |
| brk_wdata | input | 20 | New breakpoint address |
| tmr_evt | output | 1 | Timer reload pulse |
| edge_evt | output | 1 | Pin edge pulse |
| brk_evt | output | 1 | Breakpoint pulse |

## Verification
The hardest case to reach is a new edge setting that selects a pin whose level differs from the pin selected before. A careless detector reports a false edge on exactly that write, and only if the old pin's stored level disagrees with the new pin. The bench holds the previously selected pin low and the target pin high, then writes the new setting with every edge type enabled and checks that no pulse follows. The timer is swept over periods 1 to 12 and restarted in mid-count. The edge detector is swept over all four types on pins at both ends of the vector. The breakpoint is exercised by holding the execution address at the target.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int PIN_COUNT  = 64;
    localparam int PIN_IDX_W  = $clog2(PIN_COUNT);
    localparam int EDGE_CFG_W = 2 + PIN_IDX_W;
    localparam int PERIOD_W   = 32;
    localparam int XADDR_W    = 20;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef struct packed {
        edge_mode_e             mode;
        logic [PIN_IDX_W-1:0]   pin;
    } edge_cfg_t;

    typedef struct packed {
        logic [PERIOD_W-1:0] reload;
        logic [PERIOD_W-1:0] remain;
    } tmr_state_t;

    typedef struct packed {
        logic               armed;
        logic               hit_q;
        logic [XADDR_W-1:0] target;
    } brk_state_t;

    function automatic logic edge_match(edge_mode_e mode, logic prev, logic cur);
        logic rise;
        logic fall;
        rise = ~prev & cur;
        fall = prev & ~cur;
        case (mode)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_ANY:  return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int W = PERIOD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic         evt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] reload_q;
    logic [W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            remain_q <= '0;
            evt      <= 1'b0;
        end else if (we) begin
            reload_q <= wdata;
            remain_q <= wdata;
            evt      <= 1'b0;
        end else if (reload_q != '0) begin
            if (remain_q <= ONE) begin
                remain_q <= reload_q;
                evt      <= 1'b1;
            end else begin
                remain_q <= remain_q - ONE;
                evt      <= 1'b0;
            end
        end else begin
            evt <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_edge.sv
module evt_edge
    import evt_pkg::*;
#(
    parameter int NPIN = PIN_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  pins,
    input  logic             we,
    input  logic [EDGE_CFG_W-1:0] wdata,
    output logic             evt
);
    edge_cfg_t cfg_q;
    edge_cfg_t cfg_new;
    logic      prev_q;
    logic      cur_lvl;

    assign cfg_new = edge_cfg_t'(wdata);
    assign cur_lvl = pins[cfg_q.pin];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{mode: EDGE_OFF, pin: '0};
            prev_q <= 1'b0;
            evt    <= 1'b0;
        end else if (we) begin
            cfg_q  <= cfg_new;
            prev_q <= pins[cfg_new.pin];
            evt    <= 1'b0;
        end else begin
            prev_q <= cur_lvl;
            evt    <= edge_match(cfg_q.mode, prev_q, cur_lvl);
        end
    end
endmodule

// File: rtl/evt_brk.sv
module evt_brk
    import evt_pkg::*;
#(
    parameter int AW = XADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    output logic          evt
);
    logic          armed_q;
    logic          hit_q;
    logic [AW-1:0] target_q;
    logic          hit;

    assign hit = armed_q && (addr == target_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            hit_q    <= 1'b0;
            target_q <= '0;
            evt      <= 1'b0;
        end else if (we) begin
            armed_q  <= 1'b1;
            hit_q    <= 1'b0;
            target_q <= wdata;
            evt      <= 1'b0;
        end else begin
            hit_q <= hit;
            evt   <= hit & ~hit_q;
        end
    end
endmodule

// File: rtl/evt_source_unit.sv
module evt_source_unit
    import evt_pkg::*;
#(
    parameter int NPIN = PIN_COUNT,
    parameter int PW   = PERIOD_W,
    parameter int AW   = XADDR_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPIN-1:0]       pin_in,
    input  logic [AW-1:0]         exec_addr,
    input  logic                  period_we,
    input  logic [PW-1:0]         period_wdata,
    input  logic                  edge_we,
    input  logic [EDGE_CFG_W-1:0] edge_wdata,
    input  logic                  brk_we,
    input  logic [AW-1:0]         brk_wdata,
    output logic                  tmr_evt,
    output logic                  edge_evt,
    output logic                  brk_evt
);
    evt_timer #(.W(PW)) u_timer (
        .clk(clk), .rst(rst), .we(period_we), .wdata(period_wdata), .evt(tmr_evt)
    );

    evt_edge #(.NPIN(NPIN)) u_edge (
        .clk(clk), .rst(rst), .pins(pin_in), .we(edge_we), .wdata(edge_wdata),
        .evt(edge_evt)
    );

    evt_brk #(.AW(AW)) u_brk (
        .clk(clk), .rst(rst), .addr(exec_addr), .we(brk_we), .wdata(brk_wdata),
        .evt(brk_evt)
    );
endmodule

// File: rtl/evt_source_chk.sv
module evt_source_chk
    import evt_pkg::*;
#(
    parameter int NPIN = PIN_COUNT,
    parameter int PW   = PERIOD_W,
    parameter int AW   = XADDR_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NPIN-1:0]       pin_in,
    input logic [AW-1:0]         exec_addr,
    input logic                  period_we,
    input logic [PW-1:0]         period_wdata,
    input logic                  edge_we,
    input logic [EDGE_CFG_W-1:0] edge_wdata,
    input logic                  brk_we,
    input logic [AW-1:0]         brk_wdata,
    input logic                  tmr_evt,
    input logic                  edge_evt,
    input logic                  brk_evt
);
    logic [PW-1:0] seen_period;
    logic [PW-1:0] gap;
    logic          seen_armed;
    logic [AW-1:0] seen_target;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_period <= '0;
            gap         <= '0;
            seen_armed  <= 1'b0;
            seen_target <= '0;
        end else begin
            if (period_we) begin
                seen_period <= period_wdata;
                gap         <= '0;
            end else if (tmr_evt) begin
                gap <= PW'(1);
            end else begin
                gap <= gap + PW'(1);
            end
            if (brk_we) begin
                seen_armed  <= 1'b1;
                seen_target <= brk_wdata;
            end
        end
    end

    // R2
    tmr_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_evt |-> (gap == seen_period));

    // R3
    tmr_off_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_period == '0) |-> !tmr_evt);

    // R4
    tmr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        period_we |=> !tmr_evt);

    // R7
    edge_cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        edge_we |=> !edge_evt);

    // R8
    brk_addr_chk: assert property (@(posedge clk) disable iff (rst)
        brk_evt |-> (seen_armed && $past(exec_addr) == seen_target));

    // R8
    brk_single_chk: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> !brk_evt);

    // R9
    brk_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_armed |-> !brk_evt);
endmodule

bind evt_source_unit evt_source_chk #(.NPIN(NPIN), .PW(PW), .AW(AW)) u_chk (.*);

// File: tb/evt_source_unit_test.sv
module evt_source_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] pin_in = '0;
    logic [19:0] exec_addr = '0;
    logic        period_we = 1'b0;
    logic [31:0] period_wdata = '0;
    logic        edge_we = 1'b0;
    logic [7:0]  edge_wdata = '0;
    logic        brk_we = 1'b0;
    logic [19:0] brk_wdata = '0;
    logic        tmr_evt, edge_evt, brk_evt;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    evt_source_unit uut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic wr_period(logic [31:0] p);
        period_we = 1'b1; period_wdata = p; step(); period_we = 1'b0;
    endtask

    task automatic wr_edge(logic [1:0] mode, int pin);
        edge_we = 1'b1; edge_wdata = {mode, 6'(pin)}; step(); edge_we = 1'b0;
    endtask

    task automatic wr_brk(logic [19:0] a);
        brk_we = 1'b1; brk_wdata = a; step(); brk_we = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int pins_sel[4];
        int addrs[5];
        pins_sel = '{0, 1, 37, 63};
        addrs = '{20'h0, 20'h7FC, 20'h800, 20'hFFFFF, 20'h12345};
        step(); step();
        rst = 1'b0;
        // R1 reset state, with pins and address active
        pin_in = '1; exec_addr = 20'h0;
        for (int i = 0; i < 6; i++) begin
            step();
            pin_in = ~pin_in;
            chk("R1 tmr", tmr_evt, 1'b0);
            chk("R1 edge", edge_evt, 1'b0);
            chk("R1/R9 brk", brk_evt, 1'b0);
        end
        pin_in = '0;

        // R2 period sweep
        for (int p = 1; p <= 12; p++) begin
            wr_period(32'(p));
            chk("R2 after write", tmr_evt, 1'b0);
            for (int n = 1; n <= 3 * p; n++) begin
                step();
                chk("R2 period", tmr_evt, (n % p) == 0);
            end
        end

        // R3 zero period
        wr_period(32'd0);
        for (int n = 0; n < 30; n++) begin
            step();
            chk("R3 off", tmr_evt, 1'b0);
        end

        // R4 restart mid-count
        wr_period(32'd10);
        for (int n = 1; n <= 6; n++) begin step(); chk("R4 pre", tmr_evt, 1'b0); end
        wr_period(32'd10);
        for (int n = 1; n <= 10; n++) begin
            step();
            chk("R4 restart", tmr_evt, n == 10);
        end
        wr_period(32'd0);

        // R5/R6 edge type and pin sweep
        for (int m = 0; m < 4; m++) begin
            foreach (pins_sel[k]) begin
                int pn;
                int other;
                pn = pins_sel[k];
                other = (pn == 0) ? 5 : pn - 1;
                pin_in = '0;
                wr_edge(2'(m), pn);
                chk("R7 write", edge_evt, 1'b0);
                pin_in[pn] = 1'b1; step();
                chk("R5/R6 rise", edge_evt, m[0]);
                step();
                chk("R6 hold high", edge_evt, 1'b0);
                pin_in[pn] = 1'b0; step();
                chk("R5/R6 fall", edge_evt, m[1]);
                pin_in[other] = 1'b1; step();
                chk("R7 other pin", edge_evt, 1'b0);
                pin_in[other] = 1'b0; step();
                chk("R7 other pin", edge_evt, 1'b0);
                pin_in[pn] = 1'b1; step();
                pin_in[pn] = 1'b0; step();
                chk("R6 back-to-back fall", edge_evt, m[1]);
            end
        end

        // R7 reselect onto a pin with a different level
        pin_in = '0;
        wr_edge(2'b11, 3);
        pin_in[40] = 1'b1; step();
        chk("R7 unselected", edge_evt, 1'b0);
        wr_edge(2'b11, 40);
        chk("R7 reselect write", edge_evt, 1'b0);
        step();
        chk("R7 reselect no false edge", edge_evt, 1'b0);
        pin_in[40] = 1'b0; step();
        chk("R7 real edge after reselect", edge_evt, 1'b1);
        wr_edge(2'b00, 0);

        // R8/R9 breakpoint
        foreach (addrs[k]) begin
            exec_addr = 20'h00100;
            wr_brk(addrs[k]);
            chk("R8 write", brk_evt, 1'b0);
            step();
            chk("R8 away", brk_evt, 1'b0);
            exec_addr = addrs[k]; step();
            chk("R8/R9 hit", brk_evt, 1'b1);
            step();
            chk("R8 held", brk_evt, 1'b0);
            step();
            chk("R8 held", brk_evt, 1'b0);
            exec_addr = addrs[k] ^ 20'h00004; step();
            chk("R8 neighbour", brk_evt, 1'b0);
            exec_addr = addrs[k]; step();
            chk("R8 re-arrival", brk_evt, 1'b1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule